// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block collects level-sensitive interrupt lines from a configurable number of global sources and presents them to several hart contexts. A context is one privilege mode on one hart, so the machine-mode and supervisor-mode views of one hart are two separate contexts. Each context has its own enable bits, its own priority threshold and its own claim/complete register. Each context also has its own interrupt request line.

Software configures a 3-bit priority per source through a simple word-addressed register port. It picks up work by reading the claim register of its context. That read returns the best eligible source ID and takes that source out of the pending state. When software writes the same ID back to the same register, the source is re-armed. Read data is registered: it appears on `bus_rdata` in the cycle after the access and is zero in any cycle that follows a non-read.

Top module: `irqc_core`

## Requirements
- R1: The priority of source N is a word at byte address 4·N. Only bits [2:0] are stored, and the upper bits read as zero. The word for source 0 reads 0 and ignores writes.
- R2: The enable bits for context C sit in words at 0x2000 + 0x80·C + 4·W. Source N is bit N mod 32 of word W = N div 32. Bit 0 of word 0 stands for source 0, which always reads 0.
- R3: The threshold of context C is a word at 0x200000 + 0x1000·C, with 3 stored bits and upper bits that read zero. The claim/complete register of context C is at that address + 4. Read data appears one cycle after the read.
- R4: Input bit `irq_src[N]` high sets the pending bit of source N on the next clock edge. The pending bit stays set after the input falls. A source is eligible for a context only when it is pending, enabled for that context, and its priority is strictly greater than that context's threshold.
- R5: A claim read returns the eligible source with the highest priority. Among equal priorities the lowest ID wins. With no eligible source the read returns 0.
- R6: A claim read clears the returned source's pending bit and puts the source in service. While the source is in service it cannot become pending again, even if its input stays high.
- R7: Writing a source ID to any claim register takes that source out of service. If its input is still high, it becomes pending again one edge later. A completion that names a source not in service changes nothing.
- R8: `irq_req[C]` is high exactly when a claim read of context C would return a non-zero ID.
- R9: Contexts are independent. Enables, thresholds and claim results for one context do not depend on another context's settings.
- R10: Addresses that are unaligned, or outside the implemented sources, contexts or enable words, read as 0, and writes to them change no state.
- R11: After reset, all priorities, enables, thresholds, pending and in-service bits are 0, and all request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_SRC ([NUM_SRC:1]) | Level interrupt inputs; bit N is source N |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_req | output | NUM_CTX | Interrupt request per context |

## Verification
The hardest state to reach is a source that is in service while its input stays high. In that state the pending bit must stay clear until the completion write, then come back exactly one edge later. The bench holds several inputs high and drains them with back-to-back claims, which also exercises priority and tie-break order. It then completes one ID, idles one cycle and claims again. A stray completion aimed at a source that is only pending checks that such a write is ignored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned PRIO_W     = 3;
    localparam int unsigned EN_BASE    = 32'h0000_2000;
    localparam int unsigned EN_STRIDE  = 32'h0000_0080;
    localparam int unsigned CTX_BASE   = 32'h0020_0000;
    localparam int unsigned CTX_STRIDE = 32'h0000_1000;
    localparam int unsigned THR_OFF    = 32'h0;
    localparam int unsigned CLAIM_OFF  = 32'h4;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_PRIO,
        RK_EN,
        RK_THR,
        RK_CLAIM
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [31:0] ctx;
        logic [31:0] idx;
    } dec_t;

    // Map a byte address onto a register class plus context and index.
    function automatic dec_t addr_decode(input logic [31:0] a,
                                         input int unsigned nsrc,
                                         input int unsigned nctx,
                                         input int unsigned nwords);
        dec_t d;
        d.kind = RK_NONE;
        d.ctx  = '0;
        d.idx  = '0;
        if (a[1:0] == 2'b00) begin
            if (a < 4 * (nsrc + 1)) begin
                d.kind = RK_PRIO;
                d.idx  = a >> 2;
            end else if (a >= EN_BASE && a < EN_BASE + EN_STRIDE * nctx) begin
                if (32'(a[6:2]) < nwords) begin
                    d.kind = RK_EN;
                    d.ctx  = (a - EN_BASE) >> 7;
                    d.idx  = 32'(a[6:2]);
                end
            end else if (a >= CTX_BASE && a < CTX_BASE + CTX_STRIDE * nctx) begin
                d.ctx = (a - CTX_BASE) >> 12;
                if (32'(a[11:0]) == THR_OFF)        d.kind = RK_THR;
                else if (32'(a[11:0]) == CLAIM_OFF) d.kind = RK_CLAIM;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/irqc_gateway.sv
module irqc_gateway #(
    parameter int unsigned NUM_SRC = 63
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC:1]   src_level,
    input  logic [NUM_SRC:1]   claim_hit,
    input  logic [NUM_SRC:1]   done_hit,
    output logic [NUM_SRC:1]   pend_q,
    output logic [NUM_SRC:1]   srv_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            srv_q  <= '0;
        end else begin
            for (int s = 1; s <= NUM_SRC; s++) begin
                if (claim_hit[s]) begin
                    pend_q[s] <= 1'b0;
                    srv_q[s]  <= 1'b1;
                end else begin
                    if (done_hit[s] && srv_q[s]) srv_q[s] <= 1'b0;
                    if (src_level[s] && !srv_q[s]) pend_q[s] <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_chk
        // R6: an in-service source never shows pending
        assert_no_repend_R6: assert property (@(posedge clk) disable iff (rst)
            srv_q[g] |-> !pend_q[g]);
        // R6: a claim moves a pending source into service
        assert_claim_locks_R6: assert property (@(posedge clk) disable iff (rst)
            (claim_hit[g] && pend_q[g]) |=> (srv_q[g] && !pend_q[g]));
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int unsigned NUM_SRC = 63,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned ID_W    = 6
) (
    input  logic [NUM_SRC:1]             pend,
    input  logic [NUM_SRC:1]             en,
    input  logic [NUM_SRC:1][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]            thr,
    output logic [ID_W-1:0]              win_id
);

    logic [PRIO_W-1:0] best_p;

    // Ascending scan with strict compare: lowest ID keeps ties,
    // and starting at the threshold enforces "strictly greater".
    always_comb begin
        best_p = thr;
        win_id = '0;
        for (int s = 1; s <= NUM_SRC; s++) begin
            if (pend[s] && en[s] && (prio[s] > best_p)) begin
                best_p = prio[s];
                win_id = ID_W'(s);
            end
        end
    end

endmodule

// File: rtl/irqc_core.sv
module irqc_core
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 63,
    parameter int unsigned NUM_CTX = 4,
    parameter int unsigned ADDR_W  = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC:1]    irq_src,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_CTX-1:0]  irq_req
);

    localparam int unsigned ID_W      = $clog2(NUM_SRC + 1);
    localparam int unsigned NUM_WORDS = (NUM_SRC + 32) / 32;

    logic [NUM_SRC:1][PRIO_W-1:0] prio_q;
    logic [NUM_SRC:1]             en_q   [NUM_CTX];
    logic [PRIO_W-1:0]            thr_q  [NUM_CTX];
    logic [ID_W-1:0]              win_id [NUM_CTX];
    logic [NUM_SRC:1]             pend_q, srv_q, claim_hit, done_hit;
    logic [ID_W-1:0]              sel_win;
    logic [31:0]                  rd_val;
    dec_t                         dec;

    assign dec = addr_decode(32'(bus_addr), NUM_SRC, NUM_CTX, NUM_WORDS);

    irqc_gateway #(.NUM_SRC(NUM_SRC)) u_gw (
        .clk      (clk),
        .rst      (rst),
        .src_level(irq_src),
        .claim_hit(claim_hit),
        .done_hit (done_hit),
        .pend_q   (pend_q),
        .srv_q    (srv_q)
    );

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        irqc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
            .pend  (pend_q),
            .en    (en_q[c]),
            .prio  (prio_q),
            .thr   (thr_q[c]),
            .win_id(win_id[c])
        );
        assign irq_req[c] = (win_id[c] != '0);

        // R4: a reported winner really is eligible in this context
        assert_winner_eligible_R4: assert property (@(posedge clk) disable iff (rst)
            irq_req[c] |-> (pend_q[win_id[c]] && en_q[c][win_id[c]]
                            && (prio_q[win_id[c]] > thr_q[c])));
        // R8: with the request low, a claim read returns 0
        assert_quiet_claim_zero_R8: assert property (@(posedge clk) disable iff (rst)
            (bus_sel && !bus_wr && dec.kind == RK_CLAIM && dec.ctx == c && !irq_req[c])
            |=> (bus_rdata == 32'd0));
    end

    // Winner of the addressed context
    always_comb begin
        sel_win = '0;
        for (int c = 0; c < NUM_CTX; c++)
            if (dec.ctx == c) sel_win = win_id[c];
    end

    // Claim / complete strobes to the gateway
    always_comb begin
        claim_hit = '0;
        done_hit  = '0;
        if (bus_sel && dec.kind == RK_CLAIM) begin
            for (int s = 1; s <= NUM_SRC; s++) begin
                if (bus_wr) done_hit[s]  = (bus_wdata == 32'(s));
                else        claim_hit[s] = (sel_win == ID_W'(s));
            end
        end
    end

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
            for (int c = 0; c < NUM_CTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
        end else if (bus_sel && bus_wr) begin
            case (dec.kind)
                RK_PRIO: for (int s = 1; s <= NUM_SRC; s++)
                    if (dec.idx == s) prio_q[s] <= bus_wdata[PRIO_W-1:0];
                RK_EN: for (int c = 0; c < NUM_CTX; c++)
                    for (int s = 1; s <= NUM_SRC; s++)
                        if (dec.ctx == c && dec.idx == s / 32) en_q[c][s] <= bus_wdata[s % 32];
                RK_THR: for (int c = 0; c < NUM_CTX; c++)
                    if (dec.ctx == c) thr_q[c] <= bus_wdata[PRIO_W-1:0];
                default: ;
            endcase
        end
    end

    // Read mux
    always_comb begin
        rd_val = '0;
        case (dec.kind)
            RK_PRIO: for (int s = 1; s <= NUM_SRC; s++)
                if (dec.idx == s) rd_val = 32'(prio_q[s]);
            RK_EN: for (int c = 0; c < NUM_CTX; c++)
                for (int s = 1; s <= NUM_SRC; s++)
                    if (dec.ctx == c && dec.idx == s / 32) rd_val[s % 32] = en_q[c][s];
            RK_THR: for (int c = 0; c < NUM_CTX; c++)
                if (dec.ctx == c) rd_val = 32'(thr_q[c]);
            RK_CLAIM: rd_val = 32'(sel_win);
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= (bus_sel && !bus_wr) ? rd_val : 32'd0;
    end

    // R1: priority words never return bits above the stored field
    assert_prio_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && dec.kind == RK_PRIO) |=> (bus_rdata[31:PRIO_W] == '0));

    // R10: unmapped reads return zero
    assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && dec.kind == RK_NONE) |=> (bus_rdata == 32'd0));

endmodule

// File: tb/test_irqc_core.sv
module test_irqc_core;

    localparam int NS = 63;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS:1]   irq_src = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [23:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] irq_req;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    irqc_core #(.NUM_SRC(NS), .NUM_CTX(NC), .ADDR_W(24)) i_irqc_core (
        .clk(clk), .rst(rst), .irq_src(irq_src),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
    );

    always #10 clk = ~clk;

    function automatic logic [23:0] a_prio(int id);       return 24'(4 * id); endfunction
    function automatic logic [23:0] a_en(int c, int w);   return 24'('h2000 + 'h80 * c + 4 * w); endfunction
    function automatic logic [23:0] a_thr(int c);         return 24'('h200000 + 'h1000 * c); endfunction
    function automatic logic [23:0] a_clm(int c);         return 24'('h200000 + 'h1000 * c + 4); endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [23:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [23:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        irq_src = '0; bus_sel = 1'b0; rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        chk("R11 irq_req", 32'(irq_req), 0);
        rd(a_prio(1), v);  chk("R11 prio", v, 0);
        rd(a_en(0, 0), v); chk("R11 enable", v, 0);
        rd(a_thr(2), v);   chk("R11 threshold", v, 0);
        rd(a_clm(0), v);   chk("R11 claim", v, 0);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        do_reset();
        wr(a_prio(5), 32'hFFFF_FFFF);  rd(a_prio(5), v);  chk("R1 prio width", v, 7);
        wr(a_prio(63), 32'h12);        rd(a_prio(63), v); chk("R1 prio last", v, 2);
        wr(a_prio(0), 32'h7);          rd(a_prio(0), v);  chk("R1 prio src0", v, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        do_reset();
        wr(a_en(1, 0), 32'hFFFF_FFFF); rd(a_en(1, 0), v); chk("R2 enable word0", v, 32'hFFFF_FFFE);
        wr(a_en(1, 1), 32'h8000_0001); rd(a_en(1, 1), v); chk("R2 enable word1", v, 32'h8000_0001);
        rd(a_en(0, 1), v); chk("R9 enable other ctx", v, 0);
    endtask

    task automatic t_thr();
        logic [31:0] v;
        do_reset();
        wr(a_thr(3), 32'hFD); rd(a_thr(3), v); chk("R3 threshold", v, 5);
        rd(a_thr(0), v); chk("R9 threshold other ctx", v, 0);
    endtask

    task automatic t_elig();
        logic [31:0] v;
        do_reset();
        wr(a_prio(3), 2);
        wr(a_en(0, 0), 32'h8);
        wr(a_thr(0), 2);
        irq_src[3] = 1'b1;
        idle(2);
        irq_src[3] = 1'b0;
        idle(1);
        chk("R4 prio equal threshold", 32'(irq_req), 0);
        wr(a_thr(0), 1);
        chk("R4 prio above threshold, latched", 32'(irq_req), 1);
        wr(a_en(0, 0), 0);
        chk("R4 disabled", 32'(irq_req), 0);
        rd(a_clm(0), v); chk("R8 claim when idle", v, 0);
    endtask

    task automatic t_arb();
        logic [31:0] v;
        do_reset();
        wr(a_prio(4), 3); wr(a_prio(10), 3); wr(a_prio(20), 5); wr(a_prio(7), 1);
        wr(a_en(0, 0), (32'd1 << 4) | (32'd1 << 7) | (32'd1 << 10) | (32'd1 << 20));
        irq_src[4] = 1'b1; irq_src[10] = 1'b1; irq_src[20] = 1'b1;
        idle(2);
        rd(a_clm(0), v); chk("R5 highest prio", v, 20);
        rd(a_clm(0), v); chk("R5 tie lowest id", v, 4);
        rd(a_clm(0), v); chk("R5 next", v, 10);
        rd(a_clm(0), v); chk("R6 no repend while in service", v, 0);
        chk("R8 request low after drain", 32'(irq_req), 0);
        wr(a_clm(0), 4);
        idle(1);
        rd(a_clm(0), v); chk("R7 complete rearms", v, 4);
        irq_src[7] = 1'b1;
        idle(2);
        irq_src[7] = 1'b0;
        wr(a_clm(0), 7);
        rd(a_clm(0), v); chk("R7 stray complete ignored", v, 7);
        rd(a_clm(0), v); chk("R5 empty", v, 0);
    endtask

    task automatic t_ctx();
        logic [31:0] v;
        do_reset();
        wr(a_prio(12), 4);
        wr(a_en(1, 0), 32'd1 << 12);
        irq_src[12] = 1'b1;
        idle(2);
        chk("R9 only ctx1 requests", 32'(irq_req), 2);
        rd(a_clm(0), v); chk("R9 ctx0 claim empty", v, 0);
        rd(a_clm(1), v); chk("R9 ctx1 claim", v, 12);
        chk("R8 request drops after claim", 32'(irq_req), 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        do_reset();
        wr(a_prio(5), 6);
        wr(24'h001000, 32'hFFFF_FFFF);
        wr(24'h002200, 32'hFFFF_FFFF);
        wr(24'h002008, 32'hFFFF_FFFF);
        wr(24'h200008, 32'hFFFF_FFFF);
        wr(24'h000100, 32'hFFFF_FFFF);
        wr(24'h000015, 32'hFFFF_FFFF);
        rd(24'h001000, v); chk("R10 gap read", v, 0);
        rd(24'h002200, v); chk("R10 ctx beyond range", v, 0);
        rd(24'h204004, v); chk("R10 claim beyond range", v, 0);
        rd(24'h000100, v); chk("R10 source beyond range", v, 0);
        rd(a_prio(5), v);  chk("R10 prio untouched", v, 6);
        rd(a_en(0, 0), v); chk("R10 enable untouched", v, 0);
        rd(a_en(0, 1), v); chk("R10 enable word1 untouched", v, 0);
        rd(a_thr(0), v);   chk("R10 threshold untouched", v, 0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_prio();
        t_enable();
        t_thr();
        t_elig();
        t_arb();
        t_ctx();
        t_unmapped();
        summary();
    end

endmodule